// File: doc/BRIEF.md
# Priority Nesting Status Register

This block keeps an 8-bit record of which fast-interrupt priority levels are currently in service. Level 0 is the most urgent and level 7 the least. When the core acknowledges an interrupt it presents the level index on the acknowledge input, and the bit for that level is recorded. Firmware retires a level by issuing a write strobe. Each strobe retires exactly one level, which is always the most urgent one still recorded. A less urgent level therefore never leaves the record while a more urgent one is still open.

A combinational gate tells the surrounding interrupt logic whether a pending request at a given level may be taken now. A nesting-enable input selects the rule. With nesting enabled, a request may preempt only when it is more urgent than every level in service. With nesting disabled, a request is taken only when nothing is in service. The record is visible as a 32-bit read word. Level selection by an arbiter and vectoring of the core lie outside this block.

Top module: `nest_status_reg`

## Requirements
- R1: After reset, the read word is 0x00000000.
- R2: An acknowledge with level index k sets read bit k at the next clock edge. Bit k stands for level k, and bit 0 is the most urgent level.
- R3: A write strobe clears exactly one bit: the set bit with the lowest index.
- R4: A write strobe while the record is all zeros leaves the record at zero.
- R5: A write strobe leaves every bit other than the lowest-index set bit unchanged. With no strobe and no acknowledge, the record holds its value.
- R6: When an acknowledge and a write strobe occur in the same cycle, the clear is applied first and the set second. An acknowledge of the very level being cleared leaves that bit set.
- R7: With nest_en at 1, preempt_ok is 1 exactly when the record is zero or req_level is lower than the lowest set index.
- R8: With nest_en at 0, preempt_ok is 1 exactly when the record is zero.
- R9: Read bits 31 to 8 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe that retires the most urgent level in service |
| ack_valid | input | 1 | Acknowledge pulse for one level |
| ack_level | input | 3 | Index of the level being acknowledged |
| nest_en | input | 1 | 1 = nested prioritized servicing, 0 = no nesting |
| req_level | input | 3 | Index of the level asking to be taken |
| rd_data | output | 32 | Read word holding the record in bits 7 to 0 |
| preempt_ok | output | 1 | The request at req_level may be taken now |

## Verification
The retire function is tested from three kinds of starting record: a sparse record with two levels in service, a scattered pattern with non-adjacent bits, and a full record drained down to empty. Together these show whether a strobe clears the lowest index only, clears one bit or several, and leaves the other bits alone. Cases where the acknowledge and the strobe fall in the same cycle check the order of clear and set. One of these cases acknowledges the level being retired, which tells clear-then-set apart from set-then-clear. The gate is tested with requests above, equal to and below the most urgent level in service, under both nesting settings. This separates a strict comparison from a non-strict one, and nesting from no nesting.

// File: rtl/nest_pkg.sv
package nest_pkg;
    localparam int NEST_LEVELS = 8;
    localparam int NEST_REG_W  = 32;

    typedef enum logic {
        NEST_OFF = 1'b0,
        NEST_ON  = 1'b1
    } nest_mode_e;
endpackage

// File: rtl/nest_lowest_find.sv
module nest_lowest_find #(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic [N-1:0]     lowest_oh,
    output logic [IDX_W-1:0] lowest_idx,
    output logic             any_set
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_scan
        assign seen[i+1]    = seen[i] | vec[i];
        assign lowest_oh[i] = vec[i] & ~seen[i];
    end

    assign any_set = seen[N];

    always_comb begin
        lowest_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                lowest_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/nest_level_decode.sv
module nest_level_decode #(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             valid,
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     onehot
);
    for (genvar i = 0; i < N; i++) begin : g_dec
        assign onehot[i] = valid && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/nest_preempt_gate.sv
module nest_preempt_gate #(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                 any_active,
    input  logic [IDX_W-1:0]     top_idx,
    input  logic [IDX_W-1:0]     req_idx,
    input  nest_pkg::nest_mode_e mode,
    output logic                 ok
);
    logic more_urgent;

    assign more_urgent = req_idx < top_idx;

    always_comb begin
        if (!any_active) begin
            ok = 1'b1;
        end else if (mode == nest_pkg::NEST_ON) begin
            ok = more_urgent;
        end else begin
            ok = 1'b0;
        end
    end
endmodule

// File: rtl/nest_status_reg.sv
module nest_status_reg #(
    parameter int N_LEVELS = nest_pkg::NEST_LEVELS,
    parameter int REG_W    = nest_pkg::NEST_REG_W,
    localparam int IDX_W   = $clog2(N_LEVELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             ack_valid,
    input  logic [IDX_W-1:0] ack_level,
    input  logic             nest_en,
    input  logic [IDX_W-1:0] req_level,
    output logic [REG_W-1:0] rd_data,
    output logic             preempt_ok
);
    typedef struct packed {
        logic [N_LEVELS-1:0] lvl;
    } state_t;

    state_t state_q;
    state_t state_d;

    logic [N_LEVELS-1:0] top_oh;
    logic [IDX_W-1:0]    top_idx;
    logic                any_active;
    logic [N_LEVELS-1:0] ack_oh;
    nest_pkg::nest_mode_e mode;

    assign mode = nest_en ? nest_pkg::NEST_ON : nest_pkg::NEST_OFF;

    nest_lowest_find #(.N(N_LEVELS)) find_i (
        .vec        (state_q.lvl),
        .lowest_oh  (top_oh),
        .lowest_idx (top_idx),
        .any_set    (any_active)
    );

    nest_level_decode #(.N(N_LEVELS)) dec_i (
        .valid  (ack_valid),
        .idx    (ack_level),
        .onehot (ack_oh)
    );

    nest_preempt_gate #(.N(N_LEVELS)) gate_i (
        .any_active (any_active),
        .top_idx    (top_idx),
        .req_idx    (req_level),
        .mode       (mode),
        .ok         (preempt_ok)
    );

    // The clear is applied first, then the set.
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.lvl = state_d.lvl & ~top_oh;
        end
        state_d.lvl = state_d.lvl | ack_oh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data = {{(REG_W - N_LEVELS){1'b0}}, state_q.lvl};
endmodule

// File: rtl/nest_status_chk.sv
module nest_status_chk #(
    parameter int N_LEVELS = 8,
    parameter int REG_W    = 32,
    localparam int IDX_W   = $clog2(N_LEVELS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             ack_valid,
    input logic [IDX_W-1:0] ack_level,
    input logic             nest_en,
    input logic [IDX_W-1:0] req_level,
    input logic [REG_W-1:0] rd_data,
    input logic             preempt_ok
);
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));

    p_ack_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> rd_data[$past(ack_level)]);

    p_one_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ack_valid && rd_data[N_LEVELS-1:0] != '0) |=>
        (rd_data[N_LEVELS-1:0] ==
         ($past(rd_data[N_LEVELS-1:0]) & ($past(rd_data[N_LEVELS-1:0]) - 1'b1))));

    p_empty_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ack_valid && rd_data == '0) |=> (rd_data == '0));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ack_valid) |=> $stable(rd_data));

    p_empty_preempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data == '0) |-> preempt_ok);

    p_no_nest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_en && rd_data != '0) |-> !preempt_ok);

    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:N_LEVELS] == '0);
endmodule

bind nest_status_reg nest_status_chk #(
    .N_LEVELS (N_LEVELS),
    .REG_W    (REG_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .ack_valid  (ack_valid),
    .ack_level  (ack_level),
    .nest_en    (nest_en),
    .req_level  (req_level),
    .rd_data    (rd_data),
    .preempt_ok (preempt_ok)
);

// File: tb/nest_status_reg_tb_top.sv
module nest_status_reg_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        ack_valid = 1'b0;
    logic [2:0]  ack_level = '0;
    logic        nest_en = 1'b0;
    logic [2:0]  req_level = '0;
    logic [31:0] rd_data;
    logic        preempt_ok;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nest_status_reg dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .ack_valid  (ack_valid),
        .ack_level  (ack_level),
        .nest_en    (nest_en),
        .req_level  (req_level),
        .rd_data    (rd_data),
        .preempt_ok (preempt_ok)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Inputs change 1 time unit after an edge; outputs are sampled there too.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_ack(input logic [2:0] lvl);
        ack_valid = 1'b1; ack_level = lvl;
        tick();
        ack_valid = 1'b0;
    endtask

    task automatic do_write();
        wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 8; i++) do_write();
    endtask

    task automatic t_reset();
        check("R1 reset value", rd_data, 32'h0);
        nest_en = 1'b1; req_level = 3'd5; #1;
        check("R7 empty record allows request", {31'h0, preempt_ok}, 32'h1);
    endtask

    task automatic t_ack();
        do_ack(3'd0);
        check("R2 ack level 0", rd_data, 32'h01);
        do_ack(3'd3);
        check("R2 ack level 3", rd_data, 32'h09);
        tick();
        check("R5 idle hold", rd_data, 32'h09);
    endtask

    task automatic t_retire_example();
        do_write();
        check("R3 first retire of 0x09", rd_data, 32'h08);
        do_write();
        check("R3 second retire of 0x09", rd_data, 32'h00);
    endtask

    task automatic t_scattered();
        do_ack(3'd1); do_ack(3'd2); do_ack(3'd4); do_ack(3'd7);
        check("R2 scattered set", rd_data, 32'h96);
        do_write();
        check("R3/R5 retire lowest of 0x96", rd_data, 32'h94);
        do_write();
        check("R3/R5 retire lowest of 0x94", rd_data, 32'h90);
        drain();
    endtask

    task automatic t_empty_write();
        check("R4 start empty", rd_data, 32'h0);
        do_write();
        check("R4 write to empty record", rd_data, 32'h0);
    endtask

    task automatic t_same_cycle();
        do_ack(3'd2);
        wr_en = 1'b1; ack_valid = 1'b1; ack_level = 3'd6;
        tick();
        wr_en = 1'b0; ack_valid = 1'b0;
        check("R6 clear 2 and set 6 together", rd_data, 32'h40);
        wr_en = 1'b1; ack_valid = 1'b1; ack_level = 3'd6;
        tick();
        wr_en = 1'b0; ack_valid = 1'b0;
        check("R6 ack of level being cleared", rd_data, 32'h40);
        drain();
    endtask

    task automatic t_preempt();
        do_ack(3'd4);
        nest_en = 1'b1;
        req_level = 3'd3; #1;
        check("R7 more urgent request", {31'h0, preempt_ok}, 32'h1);
        req_level = 3'd4; #1;
        check("R7 equal level request", {31'h0, preempt_ok}, 32'h0);
        req_level = 3'd7; #1;
        check("R7 less urgent request", {31'h0, preempt_ok}, 32'h0);
        req_level = 3'd0; #1;
        check("R7 most urgent request", {31'h0, preempt_ok}, 32'h1);
        nest_en = 1'b0; #1;
        check("R8 no nesting while busy", {31'h0, preempt_ok}, 32'h0);
        drain();
        req_level = 3'd7; #1;
        check("R8 no nesting when empty", {31'h0, preempt_ok}, 32'h1);
    endtask

    task automatic t_full_drain();
        logic [7:0] exp;
        for (int i = 0; i < 8; i++) do_ack(3'(i));
        check("R2 full record", rd_data, 32'hFF);
        exp = 8'hFF;
        for (int i = 0; i < 8; i++) begin
            do_write();
            exp = exp & (exp - 8'd1);
            check("R3/R5 drain step", rd_data, {24'h0, exp});
            check("R9 upper bits zero", {rd_data[31:8], 8'h0}, 32'h0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        check("R1 value after release", rd_data, 32'h0);
        t_ack();
        t_retire_example();
        t_scattered();
        t_empty_write();
        t_same_cycle();
        t_preempt();
        t_full_drain();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule